// File: doc/BRIEF.md
# Chained Buffer Transfer Channel

This block is the transfer engine of one I/O channel. It holds a small control memory with three words for each direction: a control word, which encodes the transfer unit, a chain-enable bit and the remaining unit count; an address pointer to the next unit's memory location; and a chain pointer to the next descriptor. An initiate request writes the control word and the address pointer for one direction and starts the engine.

Once started, the engine moves data between a simple byte-addressed memory port and a device handshake port. In the input direction data goes from the device to memory. In the output direction data goes from memory to the device. Each unit is a byte, a 16-bit word or a 32-bit word. After every unit, the engine writes the reduced count and the advanced pointer back into its control memory. When the count is zero, it does one of two things. If chaining is off, it stops. If chaining is on, it reads a two-word descriptor (a new control word and a new pointer) from the chain pointer address and carries on.

A descriptor with a zero count ends the chain. At the end of a transfer or chain, the engine raises a done flag and gives a one-cycle completion interrupt. A read port returns any control memory word at any time. A load port writes single words, such as the chain pointers, while the engine is idle.

Top module: `chain_dma_channel`

## Requirements
- R1: After reset, all six control memory words read as zero, and `busy`, `doneFlag` and `cmplIrq` are low.
- R2: An initiate request accepted while idle (`initReady` high) writes `initBcw` and `initBap` into the selected direction's control word and address pointer. The input direction (`initDir`=0) uses slots 0 and 1; the output direction (`initDir`=1) uses slots 3 and 4. On the next cycle `busy` is high and `doneFlag` is clear.
- R3: Control word fields are as follows. Bits [1:0] give the unit: 0 is a byte, 1 is a 16-bit word, 2 or 3 is a 32-bit word. Bit 2 enables chaining. Bits [23:8] hold the remaining count.
- R4: In the input direction, each unit accepted from the device (`devInValid` and `devInReady`) is written to memory at the address pointer. Byte k of `memWdata` goes to address `memAddr`+k. `memByteEn` is set only for the unit's bytes, and unused data bytes are zero.
- R5: In the output direction, `devOutData` carries the memory word read at the address pointer, masked to the unit width (upper bytes zero). The unit is consumed when `devOutReady` is high.
- R6: After each unit, the count in the control word drops by one and the address pointer rises by 1, 2 or 4. Both updated values can be read back through the read port. No unit moves while the count is zero.
- R7: When the count is zero and chaining is off, the engine returns to idle. `doneFlag` is set, and `cmplIrq` is high for exactly one cycle.
- R8: When the count is zero and chaining is on, the engine reads a new control word at the chain pointer and a new address pointer at the chain pointer + 4. It advances the chain pointer (slot 2 for input, slot 5 for output) by 8 and continues with the new buffer.
- R9: A fetched control word whose count is zero ends the chain. The word is stored as the control word, the chain pointer is not advanced, and the completion of R7 follows.
- R10: `cmRdData` returns the control memory word at `cmRdAddr` (slots 0 to 5) in the same cycle, at any time, without affecting a transfer. Addresses 6 and 7 read as zero.
- R11: The load port (`cmWrEn`, `cmWrAddr`, `cmWrData`) writes one control memory word while the engine is idle. While `busy` is high, a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| initValid | input | 1 | Initiate request |
| initDir | input | 1 | Direction of the request: 0 input, 1 output |
| initBcw | input | DATA_W | Control word to load |
| initBap | input | DATA_W | Address pointer to load |
| initReady | output | 1 | Engine idle, initiate accepted |
| cmWrEn | input | 1 | Control memory load strobe |
| cmWrAddr | input | 3 | Control memory slot to load |
| cmWrData | input | DATA_W | Word to load |
| cmRdAddr | input | 3 | Control memory slot to read |
| cmRdData | output | DATA_W | Word at the read slot |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| memAddr | output | DATA_W | Byte address |
| memByteEn | output | DATA_W/8 | Byte enables, byte k at memAddr+k |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, same cycle as the request |
| devInValid | input | 1 | Device offers an input unit |
| devInReady | output | 1 | Engine takes an input unit |
| devInData | input | DATA_W | Input unit |
| devOutValid | output | 1 | Engine offers an output unit |
| devOutReady | input | 1 | Device takes the output unit |
| devOutData | output | DATA_W | Output unit |
| busy | output | 1 | Transfer or chain in progress |
| doneFlag | output | 1 | Last transfer finished |
| cmplIrq | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps both directions, all three unit sizes and counts from zero to four. It checks every byte placed in memory and every unit sent to the device, so a wrong pointer step, a missing byte mask or an off-by-one count shows up as a misplaced or extra byte. A three-buffer chain with mixed widths shows whether the descriptor fetch reads the wrong word or advances the chain pointer on the terminating descriptor. The same chain run also tests whether a load-port write leaks through while the engine is busy. A zero-count initiate has to finish at once with a single interrupt, which catches a design that moves a unit before it tests the count.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int NUM_WORDS = 6;
  localparam int SLOT_W    = 3;
  localparam int CNT_LSB   = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_FETCH_BCW,
    ST_FETCH_BAP
  } dmaState_t;

  typedef struct packed {
    logic initLoad;
    logic advance;
    logic loadBcw;
    logic loadBap;
    logic stepCap;
    logic selCap;
    logic selCapHi;
  } dmaStrobe_t;

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  dmaStrobe_t          stb,
  input  logic                busy,
  input  logic                initDir,
  input  logic [DATA_W-1:0]   initBcw,
  input  logic [DATA_W-1:0]   initBap,
  input  logic                cmWrEn,
  input  logic [SLOT_W-1:0]   cmWrAddr,
  input  logic [DATA_W-1:0]   cmWrData,
  input  logic [SLOT_W-1:0]   cmRdAddr,
  output logic [DATA_W-1:0]   cmRdData,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic [DATA_W-1:0]   devInData,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W-1:0]   devOutData,
  output logic                activeDir,
  output logic [CNT_W-1:0]    curCount,
  output logic [CNT_W-1:0]    fetchCount,
  output logic                curChain
);

  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] cmWord [NUM_WORDS];
  logic [SLOT_W-1:0] slotBcw, slotBap, slotCap, initSlot;
  logic [DATA_W-1:0] curBcw, curBap, curCap, nextBcw;
  logic [2:0]        nBytes;

  assign slotBcw  = activeDir ? SLOT_W'(3) : SLOT_W'(0);
  assign slotBap  = slotBcw + SLOT_W'(1);
  assign slotCap  = slotBcw + SLOT_W'(2);
  assign initSlot = initDir ? SLOT_W'(3) : SLOT_W'(0);

  assign curBcw     = cmWord[slotBcw];
  assign curBap     = cmWord[slotBap];
  assign curCap     = cmWord[slotCap];
  assign curCount   = curBcw[CNT_LSB +: CNT_W];
  assign curChain   = curBcw[2];
  assign fetchCount = memRdata[CNT_LSB +: CNT_W];

  always_comb begin
    unique case (curBcw[1:0])
      2'd0:    nBytes = 3'd1;
      2'd1:    nBytes = 3'd2;
      default: nBytes = 3'd4;
    endcase
  end

  always_comb begin
    nextBcw = curBcw;
    nextBcw[CNT_LSB +: CNT_W] = curCount - 1'b1;
  end

  // Byte lanes enabled for the active unit width
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign memByteEn[b]         = (3'(b) < nBytes);
    assign memWdata[8*b +: 8]   = memByteEn[b] ? devInData[8*b +: 8] : 8'h00;
    assign devOutData[8*b +: 8] = memByteEn[b] ? memRdata[8*b +: 8]  : 8'h00;
  end

  assign memAddr = stb.selCap   ? curCap :
                   stb.selCapHi ? curCap + DATA_W'(BYTES) : curBap;

  assign cmRdData = (cmRdAddr < SLOT_W'(NUM_WORDS)) ? cmWord[cmRdAddr] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) cmWord[i] <= '0;
      activeDir <= 1'b0;
    end else begin
      if (stb.initLoad) begin
        cmWord[initSlot]              <= initBcw;
        cmWord[initSlot + SLOT_W'(1)] <= initBap;
        activeDir                     <= initDir;
      end else if (cmWrEn && !busy && (cmWrAddr < SLOT_W'(NUM_WORDS))) begin
        cmWord[cmWrAddr] <= cmWrData;
      end
      if (stb.advance) begin
        cmWord[slotBcw] <= nextBcw;
        cmWord[slotBap] <= curBap + DATA_W'(nBytes);
      end
      if (stb.loadBcw) cmWord[slotBcw] <= memRdata;
      if (stb.loadBap) cmWord[slotBap] <= memRdata;
      if (stb.stepCap) cmWord[slotCap] <= curCap + DATA_W'(2 * BYTES);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    stb.advance |-> (curCount != '0)); // R6
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    stb.advance |=> (curCount == $past(curCount) - 1'b1)); // R6
  AST_BAP_STEP: assert property (@(posedge clk) disable iff (rst)
    stb.advance |=> (curBap == $past(curBap) + DATA_W'($past(nBytes)))); // R6
  AST_CAP_STEP: assert property (@(posedge clk) disable iff (rst)
    stb.stepCap |=> (curCap == $past(curCap) + DATA_W'(2 * BYTES))); // R8

endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             initValid,
  input  logic             activeDir,
  input  logic [CNT_W-1:0] curCount,
  input  logic [CNT_W-1:0] fetchCount,
  input  logic             curChain,
  input  logic             devInValid,
  input  logic             devOutReady,
  output dmaStrobe_t       stb,
  output logic             initReady,
  output logic             devInReady,
  output logic             devOutValid,
  output logic             memRd,
  output logic             memWr,
  output logic             busy,
  output logic             doneFlag,
  output logic             cmplIrq
);

  dmaState_t state, stateNext;
  logic      finish;

  always_comb begin
    stb         = '0;
    stateNext   = state;
    finish      = 1'b0;
    initReady   = 1'b0;
    devInReady  = 1'b0;
    devOutValid = 1'b0;
    memRd       = 1'b0;
    memWr       = 1'b0;
    unique case (state)
      ST_IDLE: begin
        initReady = 1'b1;
        if (initValid) begin
          stb.initLoad = 1'b1;
          stateNext    = ST_XFER;
        end
      end
      ST_XFER: begin
        if (curCount == '0) begin
          if (curChain) begin
            stateNext = ST_FETCH_BCW;
          end else begin
            finish    = 1'b1;
            stateNext = ST_IDLE;
          end
        end else if (!activeDir) begin
          devInReady  = 1'b1;
          memWr       = devInValid;
          stb.advance = devInValid;
        end else begin
          memRd       = 1'b1;
          devOutValid = 1'b1;
          stb.advance = devOutReady;
        end
      end
      ST_FETCH_BCW: begin
        memRd       = 1'b1;
        stb.selCap  = 1'b1;
        stb.loadBcw = 1'b1;
        if (fetchCount == '0) begin
          finish    = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stateNext = ST_FETCH_BAP;
        end
      end
      ST_FETCH_BAP: begin
        memRd        = 1'b1;
        stb.selCapHi = 1'b1;
        stb.loadBap  = 1'b1;
        stb.stepCap  = 1'b1;
        stateNext    = ST_XFER;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      doneFlag <= 1'b0;
      cmplIrq  <= 1'b0;
    end else begin
      state   <= stateNext;
      cmplIrq <= finish;
      if (stb.initLoad)  doneFlag <= 1'b0;
      else if (finish)   doneFlag <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmplIrq |=> !cmplIrq); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    doneFlag |-> !busy); // R7

endmodule

// File: rtl/chain_dma_channel.sv
module chain_dma_channel
  import dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                initValid,
  input  logic                initDir,
  input  logic [DATA_W-1:0]   initBcw,
  input  logic [DATA_W-1:0]   initBap,
  output logic                initReady,
  input  logic                cmWrEn,
  input  logic [2:0]          cmWrAddr,
  input  logic [DATA_W-1:0]   cmWrData,
  input  logic [2:0]          cmRdAddr,
  output logic [DATA_W-1:0]   cmRdData,
  output logic                memRd,
  output logic                memWr,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                devInValid,
  output logic                devInReady,
  input  logic [DATA_W-1:0]   devInData,
  output logic                devOutValid,
  input  logic                devOutReady,
  output logic [DATA_W-1:0]   devOutData,
  output logic                busy,
  output logic                doneFlag,
  output logic                cmplIrq
);

  dmaStrobe_t       stb;
  logic             activeDir;
  logic             curChain;
  logic [CNT_W-1:0] curCount;
  logic [CNT_W-1:0] fetchCount;

  dma_control #(.CNT_W(CNT_W)) i_control (
    .clk         (clk),
    .rst         (rst),
    .initValid   (initValid),
    .activeDir   (activeDir),
    .curCount    (curCount),
    .fetchCount  (fetchCount),
    .curChain    (curChain),
    .devInValid  (devInValid),
    .devOutReady (devOutReady),
    .stb         (stb),
    .initReady   (initReady),
    .devInReady  (devInReady),
    .devOutValid (devOutValid),
    .memRd       (memRd),
    .memWr       (memWr),
    .busy        (busy),
    .doneFlag    (doneFlag),
    .cmplIrq     (cmplIrq)
  );

  dma_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .busy       (busy),
    .initDir    (initDir),
    .initBcw    (initBcw),
    .initBap    (initBap),
    .cmWrEn     (cmWrEn),
    .cmWrAddr   (cmWrAddr),
    .cmWrData   (cmWrData),
    .cmRdAddr   (cmRdAddr),
    .cmRdData   (cmRdData),
    .memRdata   (memRdata),
    .devInData  (devInData),
    .memAddr    (memAddr),
    .memByteEn  (memByteEn),
    .memWdata   (memWdata),
    .devOutData (devOutData),
    .activeDir  (activeDir),
    .curCount   (curCount),
    .fetchCount (fetchCount),
    .curChain   (curChain)
  );

endmodule

// File: tb/test_chain_dma_channel.sv
`timescale 1ns/1ps
module test_chain_dma_channel;

  logic        clk = 1'b0;
  logic        rst;
  logic        initValid, initDir, initReady;
  logic [31:0] initBcw, initBap;
  logic        cmWrEn;
  logic [2:0]  cmWrAddr, cmRdAddr;
  logic [31:0] cmWrData, cmRdData;
  logic        memRd, memWr;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0]  memByteEn;
  logic        devInValid, devInReady, devOutValid, devOutReady;
  logic [31:0] devInData, devOutData;
  logic        busy, doneFlag, cmplIrq;

  int nChecks = 0;
  int nFail   = 0;
  logic [7:0] mem [256];

  always #2.5 clk = ~clk;

  chain_dma_channel i_chain_dma_channel (.*);

  assign memRdata = {mem[8'(memAddr[7:0] + 8'd3)], mem[8'(memAddr[7:0] + 8'd2)],
                     mem[8'(memAddr[7:0] + 8'd1)], mem[memAddr[7:0]]};

  always @(posedge clk)
    if (memWr)
      for (int k = 0; k < 4; k++)
        if (memByteEn[k]) mem[8'(memAddr[7:0] + 8'(k))] <= memWdata[8*k +: 8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return {8'(i + 1), 8'(i * 3 + 7), 8'(i * 5 + 2), 8'(8'hA0 + i)};
  endfunction

  function automatic logic [31:0] mkBcw(input int cnt, input int unit, input bit chain);
    return (32'(cnt) << 8) | (32'(chain) << 2) | 32'(unit);
  endfunction

  function automatic int unitBytes(input int unit);
    return (unit == 0) ? 1 : (unit == 1) ? 2 : 4;
  endfunction

  task automatic readCm(input logic [2:0] a, output logic [31:0] v);
    cmRdAddr = a;
    #0.5;
    v = cmRdData;
  endtask

  task automatic putWord(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[8'(a + k)] = v[8*k +: 8];
  endtask

  // Issue an initiate at a negedge; checks R2 at the following negedge.
  task automatic doInit(input bit dir, input logic [31:0] bcw, input logic [31:0] bap);
    logic [31:0] v;
    @(negedge clk);
    initValid = 1'b1; initDir = dir; initBcw = bcw; initBap = bap;
    @(negedge clk);
    initValid = 1'b0;
    chk(busy === 1'b1 && doneFlag === 1'b0, "R2 busy/done after initiate", {30'd0, busy, doneFlag}, 32'h2);
    readCm(dir ? 3'd3 : 3'd0, v);
    chk(v === bcw, "R2 control word loaded", v, bcw);
    readCm(dir ? 3'd4 : 3'd1, v);
    chk(v === bap, "R2 address pointer loaded", v, bap);
  endtask

  // Serve the device side until idle; output units are checked against expOut.
  task automatic serve(input bit dir, input int unit, input int start, input bit poke,
                       output int items, output int irqs);
    int n;
    logic [31:0] e;
    n = unitBytes(unit);
    items = 0; irqs = 0;
    devOutReady = 1'b1;
    forever begin
      if (!dir) begin
        devInValid = 1'b1;
        devInData  = pat(items);
        if (devInReady) items++;
      end else begin
        if (devOutValid && devOutReady) begin
          e = '0;
          for (int b = 0; b < n; b++) e[8*b +: 8] = 8'(start + items * n + b) ^ 8'h5A;
          chk(devOutData === e, "R5 output unit", devOutData, e);
          items++;
        end
        devOutReady = ~devOutReady;
      end
      if (poke) begin
        cmWrEn = 1'b1; cmWrAddr = 3'd5; cmWrData = 32'hDEAD;
        poke = 1'b0;
      end else cmWrEn = 1'b0;
      if (cmplIrq) irqs++;
      if (!busy) break;
      @(negedge clk);
    end
    devInValid = 1'b0;
    cmWrEn     = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int items, irqs;
    rst = 1'b1; initValid = 1'b0; initDir = 1'b0; initBcw = '0; initBap = '0;
    cmWrEn = 1'b0; cmWrAddr = '0; cmWrData = '0; cmRdAddr = '0;
    devInValid = 1'b0; devInData = '0; devOutReady = 1'b0;
    for (int a = 0; a < 256; a++) mem[a] = 8'hEE;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(busy === 1'b0 && doneFlag === 1'b0 && cmplIrq === 1'b0, "R1 flags after reset",
        {29'd0, busy, doneFlag, cmplIrq}, 32'h0);
    for (int s = 0; s < 6; s++) begin
      readCm(3'(s), v);
      chk(v === 32'h0, "R1 control word zero", v, 32'h0);
    end

    // R4 R5 R6 R7 sweep over direction, unit and count (R3 encodings)
    for (int dir = 0; dir < 2; dir++)
      for (int unit = 0; unit < 3; unit++)
        for (int cnt = 0; cnt < 5; cnt++) begin
          int n;
          n = unitBytes(unit);
          for (int a = 0; a < 256; a++) mem[a] = dir ? (8'(a) ^ 8'h5A) : 8'hEE;
          doInit(dir[0], mkBcw(cnt, unit, 1'b0), 32'h20);
          serve(dir[0], unit, 32'h20, 1'b0, items, irqs);
          chk(items == cnt, "R3 unit count moved", 32'(items), 32'(cnt));
          chk(doneFlag === 1'b1 && irqs == 1, "R7 done and one interrupt",
              {31'd0, doneFlag} | 32'(irqs << 4), 32'h11);
          @(negedge clk);
          chk(cmplIrq === 1'b0, "R7 interrupt single cycle", {31'd0, cmplIrq}, 32'h0);
          readCm(dir ? 3'd3 : 3'd0, v);
          chk(v === mkBcw(0, unit, 1'b0), "R6 count written back", v, mkBcw(0, unit, 1'b0));
          readCm(dir ? 3'd4 : 3'd1, v);
          chk(v === 32'(32'h20 + cnt * n), "R6 pointer written back", v, 32'(32'h20 + cnt * n));
          if (!dir) begin
            for (int i = 0; i < cnt; i++)
              for (int b = 0; b < n; b++)
                chk(mem[8'(32'h20 + i * n + b)] === pat(i)[8*b +: 8], "R4 byte placed",
                    {24'd0, mem[8'(32'h20 + i * n + b)]}, {24'd0, pat(i)[8*b +: 8]});
            chk(mem[8'(32'h20 + cnt * n)] === 8'hEE, "R4 no write past buffer",
                {24'd0, mem[8'(32'h20 + cnt * n)]}, 32'hEE);
          end
        end

    // R11 load while idle, R10 read port
    for (int a = 0; a < 256; a++) mem[a] = 8'hEE;
    @(negedge clk);
    cmWrEn = 1'b1; cmWrAddr = 3'd2; cmWrData = 32'h80;
    @(negedge clk);
    cmWrEn = 1'b0;
    readCm(3'd2, v);
    chk(v === 32'h80, "R11 idle load of chain pointer", v, 32'h80);
    readCm(3'd6, v);
    chk(v === 32'h0, "R10 unused slot reads zero", v, 32'h0);

    // R8 R9 chain: 32-bit x1, 16-bit x2, byte x3, then a terminator
    putWord(32'h80, mkBcw(2, 1, 1'b1));
    putWord(32'h84, 32'h40);
    putWord(32'h88, mkBcw(3, 0, 1'b1));
    putWord(32'h8C, 32'h50);
    putWord(32'h90, 32'h0000_0006);
    doInit(1'b0, mkBcw(1, 2, 1'b1), 32'h30);
    readCm(3'd2, v);
    chk(v === 32'h80, "R10 read during transfer", v, 32'h80);
    serve(1'b0, 2, 32'h30, 1'b1, items, irqs);
    chk(items == 6, "R8 units across chain", 32'(items), 32'd6);
    chk(doneFlag === 1'b1 && irqs == 1, "R9 chain end completion",
        {31'd0, doneFlag} | 32'(irqs << 4), 32'h11);
    for (int b = 0; b < 4; b++)
      chk(mem[8'(32'h30 + b)] === pat(0)[8*b +: 8], "R8 first buffer byte",
          {24'd0, mem[8'(32'h30 + b)]}, {24'd0, pat(0)[8*b +: 8]});
    for (int i = 0; i < 2; i++)
      for (int b = 0; b < 2; b++)
        chk(mem[8'(32'h40 + 2 * i + b)] === pat(1 + i)[8*b +: 8], "R8 second buffer byte",
            {24'd0, mem[8'(32'h40 + 2 * i + b)]}, {24'd0, pat(1 + i)[8*b +: 8]});
    for (int i = 0; i < 3; i++)
      chk(mem[8'(32'h50 + i)] === pat(3 + i)[7:0], "R8 third buffer byte",
          {24'd0, mem[8'(32'h50 + i)]}, {24'd0, pat(3 + i)[7:0]});
    chk(mem[8'h53] === 8'hEE, "R4 no write past chain", {24'd0, mem[8'h53]}, 32'hEE);
    readCm(3'd2, v);
    chk(v === 32'h90, "R9 chain pointer stops at terminator", v, 32'h90);
    readCm(3'd0, v);
    chk(v === 32'h6, "R9 terminator stored", v, 32'h6);
    readCm(3'd1, v);
    chk(v === 32'h53, "R6 pointer after chain", v, 32'h53);
    readCm(3'd5, v);
    chk(v === 32'h0, "R11 load ignored while busy", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule